// File: doc/BRIEF.md
# Peripheral clock gate controller

This block holds the enable state for up to 64 peripheral clocks, arranged as groups of 32, and drives one gate-enable output per clock. Software never has to read-modify-write: each group has one address where a one bit turns its clock on, and another where a one bit turns it off. Bits written as zero change nothing. Clock number N belongs to group N/32, at bit N mod 32.

Each clock has two separate bits. The request bit records what software asked for. The status bit records what the gate has actually done, and it follows the request only after a settling delay. Both bits can be read, so a clock that has been requested but not yet acknowledged is visible. Software polls the status word until it matches the request. The gate-enable output is the status bit itself, so it only moves when the acknowledgement moves.

A parameterised set of always-on clocks comes out of reset with request and status both set. The outputs are plain enables; they are not clock cells.

Top module: `pcg_top`

## Requirements
- R1: After reset every request bit and every status bit is zero, except the bits named in the always-on mask (bench: clocks 2 and 34), which are one. `gate_en` equals that mask and `bus_rdata` is zero.
- R2: A write to a group's set address (group 0 at 0x24, group 1 at 0x34) sets the request bit of every clock whose data bit is one. All other request bits, in that group and in the other group, keep their value.
- R3: A write to a group's clear address (group 0 at 0x28, group 1 at 0x38) clears the request bit of every clock whose data bit is one. All other request bits keep their value.
- R4: Clock N with N > 31 is controlled through group 1 at data bit N-32 and drives `gate_en[N]`. Clock N with N ≤ 31 is controlled through group 0 at data bit N.
- R5: A read of a group's request address (0x2C, 0x3C) returns that group's request mask. A read of its status address (0x30, 0x40) returns its status mask. Both are returned in `bus_rdata` one clock after the read strobe, and `bus_rdata` holds that value until the next read.
- R6: When a clock's request differs from its status and the clock is not written again, its status takes the request value exactly SETTLE clock edges (default 4) after the write edge. Until then the request read shows the new value and the status read shows the old one.
- R7: A write that carries a one for a clock restarts that clock's settle count, even while an earlier change is still pending. The status of a clock never changes on an edge at which that clock is written.
- R8: Reads of the set and clear addresses, and of any address that is not mapped, return zero.
- R9: `gate_en[N]` always equals clock N's status bit.
- R10: If a clock's request returns to its status value before the settle count expires, the status and `gate_en` of that clock do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data, one bit per clock of the addressed group |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| gate_en | output | 64 | Gate enable per clock, equal to its status bit |

## Verification
The assertions assume the bus issues at most one access per cycle. In particular, `bus_wr` and `bus_rd` are never high together, and addresses and data are defined whenever a strobe is high. The stimulus is driven on the falling edge, and every bus task raises exactly one strobe for exactly one cycle, so these assumptions always hold. The random phase draws addresses from the mapped offsets plus a few unmapped ones, and keeps written data sparse. This makes requests flip often enough that restarts (R7) and reverted requests (R10) occur many times during the run.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam int ADDR_W    = 8;
  localparam int FIRST_REG = 'h24;   // set register of group 0
  localparam int GRP_STEP  = 'h10;   // spacing between group register blocks

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_SET  = 3'd1,
    K_CLR  = 3'd2,
    K_REQ  = 3'd3,
    K_STAT = 3'd4
  } reg_kind_e;

  // Register kind that an address selects within group g.
  function automatic reg_kind_e kind_at(logic [ADDR_W-1:0] addr, int g);
    int base;
    base = FIRST_REG + g * GRP_STEP;
    if (int'(addr) == base)           return K_SET;
    else if (int'(addr) == base + 4)  return K_CLR;
    else if (int'(addr) == base + 8)  return K_REQ;
    else if (int'(addr) == base + 12) return K_STAT;
    return K_NONE;
  endfunction

  // New request word: clearing wins over setting for a bit hit by both.
  function automatic logic [31:0] req_next(logic [31:0] cur, logic [31:0] setm,
                                           logic [31:0] clrm);
    return (cur | setm) & ~clrm;
  endfunction

endpackage

// File: rtl/pcg_decode.sv
module pcg_decode
  import pcg_pkg::*;
#(
  parameter int N_GRP = 2,
  parameter int GW    = 32,
  localparam int N_CLK = N_GRP * GW,
  localparam int GIW   = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [GW-1:0]     wdata,
  output logic [N_CLK-1:0]  set_all,
  output logic [N_CLK-1:0]  clr_all,
  output reg_kind_e         rd_kind,
  output logic [GIW-1:0]    rd_grp
);

  for (genvar g = 0; g < N_GRP; g++) begin : g_wr
    reg_kind_e k;
    assign k = kind_at(addr, g);
    assign set_all[g*GW +: GW] = (wr_en && k == K_SET) ? wdata : '0;
    assign clr_all[g*GW +: GW] = (wr_en && k == K_CLR) ? wdata : '0;
  end

  always_comb begin
    rd_kind = K_NONE;
    rd_grp  = '0;
    if (rd_en) begin
      for (int g = 0; g < N_GRP; g++) begin
        if (kind_at(addr, g) != K_NONE) begin
          rd_kind = kind_at(addr, g);
          rd_grp  = GIW'(g);
        end
      end
    end
  end

endmodule

// File: rtl/pcg_settle_cell.sv
module pcg_settle_cell #(
  parameter int   SETTLE  = 4,
  parameter logic RST_VAL = 1'b0,
  localparam int  CW      = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,     // current request bit
  input  logic touch,   // this clock written on this edge
  output logic stat,
  output logic ack      // status takes the request on this edge
);

  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;
  logic          pend;

  assign pend = (req != stat);
  assign ack  = !touch && pend && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= RST_VAL;
      cnt  <= '0;
    end else if (touch) begin
      cnt <= '0;
    end else if (pend) begin
      if (cnt == LAST) begin
        stat <= req;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else begin
      cnt <= '0;
    end
  end

endmodule

// File: rtl/pcg_group.sv
module pcg_group
  import pcg_pkg::*;
#(
  parameter int          GW       = 32,
  parameter int          SETTLE   = 4,
  parameter logic [GW-1:0] RST_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] set_m,
  input  logic [GW-1:0] clr_m,
  output logic [GW-1:0] req_q,
  output logic [GW-1:0] stat,
  output logic [GW-1:0] ack
);

  logic [GW-1:0] touch;
  assign touch = set_m | clr_m;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= RST_MASK;
    else        req_q <= req_next(req_q, set_m, clr_m);
  end

  for (genvar b = 0; b < GW; b++) begin : g_cell
    pcg_settle_cell #(
      .SETTLE (SETTLE),
      .RST_VAL(RST_MASK[b])
    ) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req_q[b]),
      .touch(touch[b]),
      .stat (stat[b]),
      .ack  (ack[b])
    );
  end

endmodule

// File: rtl/pcg_top.sv
module pcg_top
  import pcg_pkg::*;
#(
  parameter int N_GRP  = 2,
  parameter int GW     = 32,
  parameter int SETTLE = 4,
  parameter logic [N_GRP*GW-1:0] ALWAYS_ON = 64'h0000_0004_0000_0004
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [GW-1:0]       bus_wdata,
  output logic [GW-1:0]       bus_rdata,
  output logic [N_GRP*GW-1:0] gate_en
);

  localparam int N_CLK = N_GRP * GW;
  localparam int GIW   = (N_GRP > 1) ? $clog2(N_GRP) : 1;

  // Named internal events, brought out for the checker.
  logic [N_CLK-1:0] set_all, clr_all, touch_all;
  logic [N_CLK-1:0] req_all, stat_all, ack_all;
  reg_kind_e        rd_kind;
  logic [GIW-1:0]   rd_grp;
  logic [GW-1:0]    rd_val;

  pcg_decode #(.N_GRP(N_GRP), .GW(GW)) u_dec (
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .set_all(set_all),
    .clr_all(clr_all),
    .rd_kind(rd_kind),
    .rd_grp (rd_grp)
  );

  assign touch_all = set_all | clr_all;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    pcg_group #(
      .GW      (GW),
      .SETTLE  (SETTLE),
      .RST_MASK(ALWAYS_ON[g*GW +: GW])
    ) u_grp (
      .clk  (clk),
      .rst_n(rst_n),
      .set_m(set_all[g*GW +: GW]),
      .clr_m(clr_all[g*GW +: GW]),
      .req_q(req_all[g*GW +: GW]),
      .stat (stat_all[g*GW +: GW]),
      .ack  (ack_all[g*GW +: GW])
    );
  end

  assign gate_en = stat_all;

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (rd_grp == GIW'(g)) begin
        if (rd_kind == K_REQ)       rd_val = req_all[g*GW +: GW];
        else if (rd_kind == K_STAT) rd_val = stat_all[g*GW +: GW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
  import pcg_pkg::*;
#(
  parameter int N_GRP = 2,
  parameter int GW    = 32,
  localparam int N_CLK = N_GRP * GW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [GW-1:0]     bus_wdata,
  input logic [GW-1:0]     bus_rdata,
  input logic [N_CLK-1:0]  gate_en,
  input logic [N_CLK-1:0]  req_all,
  input logic [N_CLK-1:0]  ack_all,
  input logic [N_CLK-1:0]  touch_all
);

  // R2: with no write, no request bit moves
  p_idle_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(req_all));

  // R6: a gate only moves toward a pending request
  p_gate_toward_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((gate_en ^ $past(gate_en)) & ~($past(req_all) ^ $past(gate_en))) == '0));

  // R7: a write to a clock blocks its status change on that edge
  p_touch_blocks_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((gate_en ^ $past(gate_en)) & $past(touch_all)) == '0));

  // R9: gate changes exactly where an acknowledge event was raised
  p_gate_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((gate_en ^ $past(gate_en)) == $past(ack_all)));

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    // R2: set bits take effect
    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && kind_at(bus_addr, g) == K_SET)
      |=> ((req_all[g*GW +: GW] & $past(bus_wdata)) == $past(bus_wdata)));

    // R2: bits written as zero hold
    p_set_others_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && kind_at(bus_addr, g) == K_SET)
      |=> (((req_all[g*GW +: GW] ^ $past(req_all[g*GW +: GW])) & ~$past(bus_wdata)) == '0));

    // R3: clear bits take effect
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && kind_at(bus_addr, g) == K_CLR)
      |=> ((req_all[g*GW +: GW] & $past(bus_wdata)) == '0));

    // R8: strobe registers read as zero
    p_strobe_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (kind_at(bus_addr, g) == K_SET || kind_at(bus_addr, g) == K_CLR))
      |=> (bus_rdata == '0));
  end

endmodule

bind pcg_top pcg_checker #(.N_GRP(N_GRP), .GW(GW)) u_pcg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .gate_en  (gate_en),
  .req_all  (req_all),
  .ack_all  (ack_all),
  .touch_all(touch_all)
);

// File: tb/tb_pcg_top.sv
module tb_pcg_top;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam logic [63:0] AON = 64'h0000_0004_0000_0004;
  localparam logic [7:0] A_SET0 = 8'h24, A_CLR0 = 8'h28, A_REQ0 = 8'h2C, A_ST0 = 8'h30;
  localparam logic [7:0] A_SET1 = 8'h34, A_CLR1 = 8'h38, A_REQ1 = 8'h3C, A_ST1 = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] gate_en;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcg_top #(.N_GRP(2), .GW(32), .SETTLE(SETTLE), .ALWAYS_ON(AON)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gate_en(gate_en)
  );

  // ---------------- reference model ----------------
  logic [63:0] m_req, m_st;
  int          m_age [64];
  logic [31:0] m_rd;
  bit          m_rd_new;

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      A_REQ0:  return m_req[31:0];
      A_ST0:   return m_st[31:0];
      A_REQ1:  return m_req[63:32];
      A_ST1:   return m_st[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = AON;
      m_st  = AON;
      foreach (m_age[i]) m_age[i] = 0;
      m_rd_new = 0;
    end else begin
      logic [63:0] s, c;
      m_rd_new = bus_rd;
      if (bus_rd) m_rd = model_read(bus_addr);
      s = '0; c = '0;
      if (bus_wr) begin
        if (bus_addr == A_SET0) s[31:0]  = bus_wdata;
        if (bus_addr == A_SET1) s[63:32] = bus_wdata;
        if (bus_addr == A_CLR0) c[31:0]  = bus_wdata;
        if (bus_addr == A_CLR1) c[63:32] = bus_wdata;
      end
      for (int i = 0; i < 64; i++) begin
        if (s[i] || c[i]) m_age[i] = 0;
        else if (m_req[i] != m_st[i]) begin
          m_age[i]++;
          if (m_age[i] == SETTLE) begin
            m_st[i]  = m_req[i];
            m_age[i] = 0;
          end
        end else m_age[i] = 0;
      end
      m_req = (m_req | s) & ~c;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R9 R6 gate_en vs model", gate_en, m_st);
      if (m_rd_new) check("R5 R8 bus_rdata vs model", {32'h0, bus_rdata}, {32'h0, m_rd});
    end
  end

  // ---------------- bus tasks (called just after a falling edge) ------
  task automatic do_write(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- directed and random stimulus ----------------
  initial begin
    logic [31:0] rv;
    logic [31:0] lfsr;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    check("R1 gate_en after reset", gate_en, AON);
    check("R1 bus_rdata after reset", {32'h0, bus_rdata}, 64'h0);
    do_read(A_REQ1, rv);
    check("R1 R5 group1 request at reset", {32'h0, rv}, 64'h4);

    // R2 R6: set clocks 4..7, pending visible, then acknowledged
    do_write(A_SET0, 32'h0000_00F0);
    do_read(A_REQ0, rv);
    check("R2 R5 request readback", {32'h0, rv}, 64'hF4);
    do_read(A_ST0, rv);
    check("R6 status still pending", {32'h0, rv}, 64'h4);
    idle(3);
    check("R6 gate after settle", gate_en, AON | 64'hF0);
    do_read(A_ST0, rv);
    check("R5 R6 status acknowledged", {32'h0, rv}, 64'hF4);

    // R4: clock 40 lives in group 1 bit 8
    do_write(A_SET1, 32'h0000_0100);
    idle(SETTLE);
    check("R4 clock 40 gate", {63'h0, gate_en[40]}, 64'h1);
    check("R4 R9 group0 untouched", {32'h0, gate_en[31:0]}, 64'hF4);

    // R3: clear clocks 4,5 only
    do_write(A_CLR0, 32'h0000_0030);
    do_read(A_REQ0, rv);
    check("R3 clear leaves others", {32'h0, rv}, 64'hC4);
    idle(SETTLE);
    check("R3 gate after clear", {32'h0, gate_en[31:0]}, 64'hC4);

    // R8: strobe and unmapped addresses read zero
    do_read(A_SET0, rv);  check("R8 set addr reads 0", {32'h0, rv}, 64'h0);
    do_read(A_CLR1, rv);  check("R8 clear addr reads 0", {32'h0, rv}, 64'h0);
    do_read(8'h00, rv);   check("R8 unmapped reads 0", {32'h0, rv}, 64'h0);

    // R7: rewrite of a pending clock restarts its count
    do_write(A_SET0, 32'h0000_0001);   // edge k
    idle(1);                           // after k+1
    do_write(A_SET0, 32'h0000_0001);   // edge k+2
    idle(2);                           // after k+4
    check("R7 no ack at original time", {63'h0, gate_en[0]}, 64'h0);
    idle(1);
    check("R7 no ack one later", {63'h0, gate_en[0]}, 64'h0);
    idle(1);
    check("R7 ack after restart", {63'h0, gate_en[0]}, 64'h1);

    // R10: request reverted before settling leaves gate alone
    do_write(A_SET0, 32'h0000_0002);
    do_write(A_CLR0, 32'h0000_0002);
    idle(2 * SETTLE);
    check("R10 reverted request no gate", {63'h0, gate_en[1]}, 64'h0);
    do_write(A_CLR1, 32'h0000_0004);   // clear always-on clock 34
    do_write(A_SET1, 32'h0000_0004);
    idle(2 * SETTLE);
    check("R10 reverted clear keeps gate", {63'h0, gate_en[34]}, 64'h1);

    // Random phase, checked by the per-clock model comparison (R2 R3 R5 R6 R7 R8 R9)
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] a;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      case (lfsr[3:0])
        4'd0, 4'd1:  a = A_SET0;
        4'd2, 4'd3:  a = A_CLR0;
        4'd4, 4'd5:  a = A_SET1;
        4'd6, 4'd7:  a = A_CLR1;
        4'd8:        a = A_REQ0;
        4'd9:        a = A_ST0;
        4'd10:       a = A_REQ1;
        4'd11:       a = A_ST1;
        4'd12:       a = 8'h44;
        default:     a = 8'h0C;
      endcase
      case (lfsr[5:4])
        2'd0, 2'd1: do_write(a, lfsr[31:16] & lfsr[15:0] & 32'h0000_FFFF
                                | {lfsr[15:0] & lfsr[31:16], 16'h0});
        2'd2:       do_read(a, rv);
        default:    idle(1 + int'(lfsr[7:6]));
      endcase
    end
    idle(2 * SETTLE);
    do_read(A_ST1, rv);
    check("R5 final group1 status", {32'h0, rv}, {32'h0, m_st[63:32]});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule